// File: doc/BRIEF.md
# Dual-Lane Modulo Address Generator

The block keeps two 16-bit address pointers, an X lane and a Y lane, and moves both of them together on a single step strobe. Each lane takes its own 4-bit signed step, which covers -8 to +7. Each lane also has its own mask register. A mask of all zeros makes the pointer step linearly across the full 16-bit space. A non-zero mask turns the pointer into a circular-buffer walker: the masked bits take the low bits of the sum, and the bits outside the mask keep their value. A filter loop can therefore run over a power-of-two block of taps, and over a block of coefficients, with no bounds compare.

Software sets up a loop in three moves. It writes each mask through that mask's write port. It loads a start address into each pointer through that pointer's load port. It then pulses the step strobe once per tap, with the two offsets it wants. Mask writes, loads and steps all take effect at the clock edge that samples them. The new addresses appear on the outputs after that edge.

Top module: `modulo_addr_gen`

## Requirements
- R1: While rst_n is low at a clock edge, both addresses become 0x0000 and both masks become zero. After reset, a step therefore moves each address linearly.
- R2: Each 4-bit offset is read as two's complement (bit 3 is the sign) and sign-extended to 16 bits. The codes 0x8 to 0xF mean -8 to -1, and the codes 0x0 to 0x7 mean 0 to +7.
- R3: When step_en is high and a lane's mask is zero, the lane's next address is (address + extended offset) modulo 2^16.
- R4: When step_en is high and a lane's mask is non-zero, the lane's next address is (address AND NOT mask) OR ((address + extended offset) AND mask). Bits where the mask is 0 keep their value.
- R5: On a step, both lanes update in the same cycle. Each lane uses only its own offset, its own mask and its own address.
- R6: A lane's load strobe puts that lane's load value into its address. A load wins over step_en in the same cycle.
- R7: A lane whose address sees neither step_en nor its load strobe holds its address.
- R8: A mask write stores the new mask at the clock edge that samples it. A step in that same cycle still uses the previous mask. Steps in later cycles use the new mask.
- R9: A mask that is not of the form 2^n-1 raises no error. The R4 formula is applied bit by bit, so with such a mask a carry out of a masked bit can still affect a higher masked bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Step both lanes this cycle |
| x_off | input | 4 | Signed step for the X lane |
| y_off | input | 4 | Signed step for the Y lane |
| x_mask_we | input | 1 | Write enable for the X mask |
| x_mask_wd | input | 16 | New X mask value |
| y_mask_we | input | 1 | Write enable for the Y mask |
| y_mask_wd | input | 16 | New Y mask value |
| x_load | input | 1 | Load the X address |
| x_load_val | input | 16 | Value to load into the X address |
| y_load | input | 1 | Load the Y address |
| y_load_val | input | 16 | Value to load into the Y address |
| x_addr | output | 16 | Current X address |
| y_addr | output | 16 | Current Y address |

## Verification
The assertions assume that every input is driven to a known value at each clock edge once reset is released. They also assume that the strobes are plain levels, sampled every cycle, with no handshake. The bench drives every input shortly after a rising edge and returns the strobes to zero when it is not using them, so no X value or half-cycle pulse reaches the block. The sweep covers every offset code on both lanes, over zero, contiguous and non-contiguous masks and over start addresses near the 16-bit and mask boundaries. Every check keeps one action per cycle, except for the deliberate load-versus-step and write-versus-step collisions.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and the lane count for the modulo address generator.
// Assumes: two lanes (X = index 0, Y = index 1), offsets narrower than addresses.
package agu_pkg;
    localparam int ADDR_W_DEF = 16;
    localparam int OFF_W_DEF  = 4;
    localparam int N_LANES    = 2;
    localparam int LANE_X     = 0;
    localparam int LANE_Y     = 1;
endpackage

// File: rtl/agu_mask_reg.sv
`timescale 1ns/1ps
// Module: agu_mask_reg
// Holds one lane's modulo mask. A write is stored at the sampling edge, and
// the stored value is the one steps in later cycles see.
// Assumes: synchronous active-low reset, which clears the mask (linear mode).
module agu_mask_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wd,
    output logic [ADDR_W-1:0] mask
);
    // Purpose: store the mask on a write, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (we) begin
            mask <= wd;
        end
    end
endmodule

// File: rtl/agu_step_unit.sv
`timescale 1ns/1ps
// Module: agu_step_unit
// Computes one lane's next address from the current address, a signed
// offset and the mask. A zero mask gives a plain 16-bit add. A non-zero
// mask lets only the masked bits take the sum.
// Assumes: the mask needs no particular shape. It is applied bit by bit.
module agu_step_unit #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [OFF_W-1:0]  off,
    input  logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] nxt
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] sum;
    logic              linear;

    // Purpose: sign-extend the offset and form the full-width sum.
    always_comb begin
        off_ext = {{EXT_W{off[OFF_W-1]}}, off};
        sum     = cur + off_ext;
        linear  = (mask == '0);
    end

    // Purpose: choose linear or masked merge of the sum into the address.
    always_comb begin
        if (linear) begin
            nxt = sum;
        end else begin
            nxt = (cur & ~mask) | (sum & mask);
        end
    end
endmodule

// File: rtl/agu_index_reg.sv
`timescale 1ns/1ps
// Module: agu_index_reg
// One lane's address register. A load takes priority over a step. With
// neither, the register holds.
// Assumes: synchronous active-low reset to address zero.
module agu_index_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              step,
    input  logic [ADDR_W-1:0] nxt,
    output logic [ADDR_W-1:0] q
);
    // Purpose: update the address with load > step > hold priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ld) begin
            q <= ld_val;
        end else if (step) begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/modulo_addr_gen.sv
`timescale 1ns/1ps
// Module: modulo_addr_gen (top)
// Two address lanes (X, Y), each with its own mask register, step unit and
// address register. One step strobe moves both lanes together.
// Assumes: the inputs are known at every clock edge once reset is released.
module modulo_addr_gen
    import agu_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int OFF_W  = OFF_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic [OFF_W-1:0]  x_off,
    input  logic [OFF_W-1:0]  y_off,
    input  logic              x_mask_we,
    input  logic [ADDR_W-1:0] x_mask_wd,
    input  logic              y_mask_we,
    input  logic [ADDR_W-1:0] y_mask_wd,
    input  logic              x_load,
    input  logic [ADDR_W-1:0] x_load_val,
    input  logic              y_load,
    input  logic [ADDR_W-1:0] y_load_val,
    output logic [ADDR_W-1:0] x_addr,
    output logic [ADDR_W-1:0] y_addr
);
    logic [N_LANES-1:0][OFF_W-1:0]  lane_off;
    logic [N_LANES-1:0]             lane_mwe;
    logic [N_LANES-1:0][ADDR_W-1:0] lane_mwd;
    logic [N_LANES-1:0]             lane_ld;
    logic [N_LANES-1:0][ADDR_W-1:0] lane_ldv;
    logic [N_LANES-1:0][ADDR_W-1:0] lane_mask;
    logic [N_LANES-1:0][ADDR_W-1:0] lane_nxt;
    logic [N_LANES-1:0][ADDR_W-1:0] lane_addr;

    // Purpose: gather the per-axis ports into lane arrays.
    always_comb begin
        lane_off[LANE_X] = x_off;
        lane_off[LANE_Y] = y_off;
        lane_mwe[LANE_X] = x_mask_we;
        lane_mwe[LANE_Y] = y_mask_we;
        lane_mwd[LANE_X] = x_mask_wd;
        lane_mwd[LANE_Y] = y_mask_wd;
        lane_ld[LANE_X]  = x_load;
        lane_ld[LANE_Y]  = y_load;
        lane_ldv[LANE_X] = x_load_val;
        lane_ldv[LANE_Y] = y_load_val;
    end

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        agu_mask_reg #(.ADDR_W(ADDR_W)) u_mask (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (lane_mwe[g]),
            .wd   (lane_mwd[g]),
            .mask (lane_mask[g])
        );

        agu_step_unit #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_step (
            .cur (lane_addr[g]),
            .off (lane_off[g]),
            .mask(lane_mask[g]),
            .nxt (lane_nxt[g])
        );

        agu_index_reg #(.ADDR_W(ADDR_W)) u_idx (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (lane_ld[g]),
            .ld_val(lane_ldv[g]),
            .step  (step_en),
            .nxt   (lane_nxt[g]),
            .q     (lane_addr[g])
        );
    end

    // Purpose: drive the per-axis address outputs.
    always_comb begin
        x_addr = lane_addr[LANE_X];
        y_addr = lane_addr[LANE_Y];
    end
endmodule

// File: rtl/modulo_addr_gen_chk.sv
`timescale 1ns/1ps
// Module: modulo_addr_gen_chk
// Assertion checker bound into modulo_addr_gen. It watches the lane arrays
// and the step strobe.
module modulo_addr_gen_chk
    import agu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             step_en,
    input logic [N_LANES-1:0][OFF_W-1:0]    lane_off,
    input logic [N_LANES-1:0]               lane_ld,
    input logic [N_LANES-1:0][ADDR_W-1:0]   lane_ldv,
    input logic [N_LANES-1:0][ADDR_W-1:0]   lane_mask,
    input logic [N_LANES-1:0][ADDR_W-1:0]   lane_addr
);
    localparam int EXT_W = ADDR_W - OFF_W;

    for (genvar g = 0; g < N_LANES; g++) begin : g_chk
        // R1
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> (lane_addr[g] == '0 && lane_mask[g] == '0));

        // R6
        load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lane_ld[g] |=> lane_addr[g] == $past(lane_ldv[g]));

        // R7
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!lane_ld[g] && !step_en) |=> $stable(lane_addr[g]));

        // R3
        linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (step_en && !lane_ld[g] && lane_mask[g] == '0) |=>
            lane_addr[g] == $past(lane_addr[g]) +
                {{EXT_W{$past(lane_off[g][OFF_W-1])}}, $past(lane_off[g])});

        // R4
        high_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (step_en && !lane_ld[g] && lane_mask[g] != '0) |=>
            ((lane_addr[g] ^ $past(lane_addr[g])) & ~$past(lane_mask[g])) == '0);
    end
endmodule

bind modulo_addr_gen modulo_addr_gen_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .lane_off (lane_off),
    .lane_ld  (lane_ld),
    .lane_ldv (lane_ldv),
    .lane_mask(lane_mask),
    .lane_addr(lane_addr)
);

// File: tb/tb_modulo_addr_gen.sv
`timescale 1ns/1ps
module tb_modulo_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        step_en;
    logic [3:0]  x_off, y_off;
    logic        x_mask_we, y_mask_we;
    logic [15:0] x_mask_wd, y_mask_wd;
    logic        x_load, y_load;
    logic [15:0] x_load_val, y_load_val;
    logic [15:0] x_addr, y_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    modulo_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .x_off(x_off), .y_off(y_off),
        .x_mask_we(x_mask_we), .x_mask_wd(x_mask_wd),
        .y_mask_we(y_mask_we), .y_mask_wd(y_mask_wd),
        .x_load(x_load), .x_load_val(x_load_val),
        .y_load(y_load), .y_load_val(y_load_val),
        .x_addr(x_addr), .y_addr(y_addr)
    );

    // Expected next address, from R2, R3, R4 and R9.
    function automatic logic [15:0] model(input logic [15:0] cur, input logic [3:0] off,
                                          input logic [15:0] m);
        int s;
        logic [15:0] sum;
        s   = (int'(off) >= 8) ? int'(off) - 16 : int'(off);
        sum = 16'(int'(cur) + s);
        if (m == 16'h0) return sum;
        return (cur & ~m) | (sum & m);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Advance one clock, then move just past the edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        step_en = 0; x_off = 0; y_off = 0;
        x_mask_we = 0; y_mask_we = 0; x_mask_wd = 0; y_mask_wd = 0;
        x_load = 0; y_load = 0; x_load_val = 0; y_load_val = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_up();
        end
    end

    initial begin
        logic [15:0] masks [6];
        logic [15:0] starts[4];
        logic [15:0] ex, ey;
        masks[0] = 16'h0000; masks[1] = 16'h0007; masks[2] = 16'h000F;
        masks[3] = 16'h00FF; masks[4] = 16'h0F0F; masks[5] = 16'h00F0;
        starts[0] = 16'h0000; starts[1] = 16'hFFFF; starts[2] = 16'h1237; starts[3] = 16'h80F8;

        idle_inputs();
        rst_n = 0;
        repeat (3) tick();
        // R1: reset clears the addresses
        chk("R1 x reset", x_addr, 16'h0000);
        chk("R1 y reset", y_addr, 16'h0000);
        rst_n = 1;
        // R1/R3: masks are zero after reset, so steps are linear (+3 and -2)
        step_en = 1; x_off = 4'h3; y_off = 4'hE;
        tick();
        step_en = 0;
        chk("R1 x linear after reset", x_addr, 16'h0003);
        chk("R1 y linear after reset", y_addr, 16'hFFFE);

        // R7: hold with no strobe
        x_off = 4'h7; y_off = 4'h7;
        tick(); tick();
        chk("R7 x hold", x_addr, 16'h0003);
        chk("R7 y hold", y_addr, 16'hFFFE);

        // Sweep: R2, R3, R4, R5, R6, R9
        for (int mi = 0; mi < 6; mi++) begin
            for (int si = 0; si < 4; si++) begin
                for (int o = 0; o < 16; o++) begin
                    x_mask_we = 1; x_mask_wd = masks[mi];
                    y_mask_we = 1; y_mask_wd = masks[5 - mi];
                    x_load = 1; x_load_val = starts[si];
                    y_load = 1; y_load_val = starts[si] ^ 16'h5A5A;
                    tick();
                    x_mask_we = 0; y_mask_we = 0; x_load = 0; y_load = 0;
                    chk("R6 x load", x_addr, starts[si]);
                    chk("R6 y load", y_addr, starts[si] ^ 16'h5A5A);
                    step_en = 1; x_off = 4'(o); y_off = 4'(15 - o);
                    tick();
                    step_en = 0;
                    ex = model(starts[si], 4'(o), masks[mi]);
                    ey = model(starts[si] ^ 16'h5A5A, 4'(15 - o), masks[5 - mi]);
                    chk(masks[mi] == 0 ? "R3 x step" : "R4 R9 x step", x_addr, ex);
                    chk("R2 R5 y step", y_addr, ey);
                end
            end
        end

        // R6: load beats a step in the same cycle (mask 0x0007 on X)
        x_mask_we = 1; x_mask_wd = 16'h0007; y_mask_we = 1; y_mask_wd = 16'h0000;
        tick();
        x_mask_we = 0; y_mask_we = 0;
        x_load = 1; x_load_val = 16'h4444; step_en = 1; x_off = 4'h1; y_off = 4'h1;
        y_load = 0;
        ey = y_addr;
        tick();
        x_load = 0; step_en = 0;
        chk("R6 x load over step", x_addr, 16'h4444);
        chk("R5 y stepped alone", y_addr, 16'(ey + 16'h1));

        // Circular walk: mask 0x0007, step +3, ten times (R4)
        x_load = 1; x_load_val = 16'h1238;
        tick();
        x_load = 0;
        ex = 16'h1238;
        for (int k = 0; k < 10; k++) begin
            step_en = 1; x_off = 4'h3;
            tick();
            step_en = 0;
            ex = model(ex, 4'h3, 16'h0007);
            chk("R4 circular walk", x_addr, ex);
        end

        // R8: a mask write in the same cycle as a step applies from the next step
        x_load = 1; x_load_val = 16'h00FE;
        tick();
        x_load = 0;
        x_mask_we = 1; x_mask_wd = 16'h0000; step_en = 1; x_off = 4'h3;
        tick();
        x_mask_we = 0;
        chk("R8 old mask used", x_addr, model(16'h00FE, 4'h3, 16'h0007));
        ex = x_addr;
        tick();
        step_en = 0;
        chk("R8 new mask used", x_addr, model(ex, 4'h3, 16'h0000));

        done = 1'b1;
        finish_up();
    end
endmodule